// File: doc/BRIEF.md
# Base Address Region Claim Decoder

This block decides which device register window claims an incoming port or memory access. It holds, for each of a small number of device slots, a set of base address windows. Each window has a stored address, a power-of-two size and a space type: port I/O or memory. It also holds two per-slot command enables, one for port I/O and one for memory. Every cycle the decoder compares the presented address and space type against every implemented window. It then registers a hit flag, the slot and window index of the claiming window, and the offset of the access inside that window.

The same block assigns addresses during enumeration. An allocation request names a slot, a window and a requested size. The size is rounded up to a power of two, the window receives the current value of a running port allocator, and the allocator then steps by a fixed stride. Software-style writes can later move a window or change its space type, and can rewrite a slot's command enables.

Top module: `bar_claim_dec`

## Requirements
- R1: After reset no window is implemented, both command enables of every slot are clear, all decode outputs are zero, and the allocator points at port 0x8000.
- R2: An allocation with a requested size from 1 to 256 stores the size rounded up to the next power of two and the current allocator value as the window address. It marks the window as port I/O and advances the allocator by 256. One cycle later `allocAck` is high and `allocAddr` shows the assigned address.
- R3: An allocation whose rounded size exceeds 256, or whose slot or window index is out of range, is refused. `allocAck` and `allocRefused` are high one cycle later, `allocAddr` is 0, and no window changes. The allocator does not move.
- R4: An allocation with requested size 0 is acknowledged without refusal. The window stays unimplemented, the allocator does not move, and `allocAddr` is 0.
- R5: A successful allocation sets the port I/O enable of its slot.
- R6: A window claims an access when its size is nonzero, its space type equals `accIsMem` (1 = memory), and base ≤ address < base + size. `hitOffset` is address − base.
- R7: The base of a port I/O window is its stored address with bits 1:0 cleared. The base of a memory window is its stored address with bits 3:0 cleared.
- R8: A port I/O window claims nothing while its slot's I/O enable is clear. A memory window claims nothing while its slot's memory enable is clear.
- R9: When several windows claim the same access, the lowest slot wins, and within a slot the lowest window index wins.
- R10: When no window claims the access, `hit`, `hitSlot`, `hitBar` and `hitOffset` are all zero.
- R11: A window write to an implemented window stores the written data with its low log2(size) bits cleared. It sets the space type from data bit 0 (1 = port I/O, 0 = memory). A write to an unimplemented window changes nothing.
- R12: A command write sets the slot's I/O enable from `cmdWrIo` and its memory enable from `cmdWrMem`.
- R13: The decode result for the address and type presented before a clock edge appears on the outputs after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation request |
| allocSlot | input | 2 | Slot index of the allocation |
| allocBar | input | 3 | Window index of the allocation |
| allocSize | input | 16 | Requested window size |
| allocAck | output | 1 | Allocation acknowledged |
| allocRefused | output | 1 | Allocation refused |
| allocAddr | output | 16 | Address assigned by the allocation |
| barWrValid | input | 1 | Window address write |
| barWrSlot | input | 2 | Slot index of the write |
| barWrBar | input | 3 | Window index of the write |
| barWrData | input | 16 | Written address; bit 0 selects port I/O |
| cmdWrValid | input | 1 | Command enable write |
| cmdWrSlot | input | 2 | Slot of the command write |
| cmdWrIo | input | 1 | New port I/O enable |
| cmdWrMem | input | 1 | New memory enable |
| accAddr | input | 16 | Access address |
| accIsMem | input | 1 | Access space: 1 memory, 0 port I/O |
| hit | output | 1 | A window claims the access |
| hitSlot | output | 2 | Slot of the claiming window |
| hitBar | output | 3 | Index of the claiming window |
| hitOffset | output | 16 | Offset inside the claiming window |

## Verification
The bench probes both ends of every window: the last byte must hit and the first byte past the end must miss. A design off by one in the upper compare would claim a neighbour's first port. Overlapping windows are placed both across slots and inside one slot. A design with reversed priority would then report the higher index. Stored addresses with low bits set are used for both space types. A design that masked with the wrong width, or did not mask at all, would move the window by a few bytes. Refused, zero-size and out-of-range allocations are followed by a good one. A design that advanced the allocator on them would hand out the wrong base.

// File: rtl/bar_claim_pkg.sv
package bar_claim_pkg;

  typedef struct packed {
    logic allocLoad;
    logic wrLoad;
    logic cmdLoad;
  } strobe_t;

  function automatic logic [31:0] roundUpPow2(input logic [31:0] req);
    logic [31:0] r;
    r = 32'd1;
    for (int i = 0; i < 31; i++) begin
      if (r < req) r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/bar_claim_ctrl.sv
module bar_claim_ctrl
  import bar_claim_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int NUM_BARS  = 6,
  parameter int ADDR_W    = 16,
  parameter int REQ_W     = 16,
  parameter int MAX_SIZE  = 256,
  parameter int STRIDE    = 256,
  parameter logic [ADDR_W-1:0] PORT_BASE = 16'h8000,
  localparam int SLOT_IW  = $clog2(NUM_SLOTS),
  localparam int BAR_IW   = $clog2(NUM_BARS),
  localparam int SIZE_W   = $clog2(MAX_SIZE) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [SLOT_IW-1:0] allocSlot,
  input  logic [BAR_IW-1:0]  allocBar,
  input  logic [REQ_W-1:0]   allocSize,
  input  logic               barWrValid,
  input  logic               cmdWrValid,
  output strobe_t            strobe,
  output logic [ADDR_W-1:0]  loadAddr,
  output logic [SIZE_W-1:0]  loadSize,
  output logic               allocAck,
  output logic               allocRefused,
  output logic [ADDR_W-1:0]  allocAddr
);

  logic [ADDR_W-1:0] nextBase;
  logic [31:0]       rounded;
  logic              inRange;
  logic              oversize;
  logic              zeroReq;
  logic              refuse;

  always_comb begin
    rounded  = roundUpPow2(32'(allocSize));
    inRange  = (int'(allocSlot) < NUM_SLOTS) && (int'(allocBar) < NUM_BARS);
    oversize = rounded > 32'(MAX_SIZE);
    zeroReq  = (allocSize == '0);
    refuse   = allocValid && (oversize || !inRange);
    strobe.allocLoad = allocValid && !refuse && !zeroReq;
    strobe.wrLoad    = barWrValid && !strobe.allocLoad;
    strobe.cmdLoad   = cmdWrValid;
    loadAddr = nextBase;
    loadSize = rounded[SIZE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextBase     <= PORT_BASE;
      allocAck     <= 1'b0;
      allocRefused <= 1'b0;
      allocAddr    <= '0;
    end else begin
      allocAck     <= allocValid;
      allocRefused <= refuse;
      allocAddr    <= strobe.allocLoad ? nextBase : '0;
      if (strobe.allocLoad) nextBase <= nextBase + ADDR_W'(STRIDE);
    end
  end

  // R3
  refused_has_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocRefused |-> allocAck);

  // R3
  refused_no_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocRefused |-> nextBase == $past(nextBase));

  // R2
  alloc_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocAck && !allocRefused && allocAddr != '0) |-> nextBase == allocAddr + ADDR_W'(STRIDE));

endmodule

// File: rtl/bar_claim_dp.sv
module bar_claim_dp
  import bar_claim_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int NUM_BARS  = 6,
  parameter int ADDR_W    = 16,
  parameter int MAX_SIZE  = 256,
  parameter int IO_LOW    = 2,
  parameter int MEM_LOW   = 4,
  localparam int SLOT_IW  = $clog2(NUM_SLOTS),
  localparam int BAR_IW   = $clog2(NUM_BARS),
  localparam int SIZE_W   = $clog2(MAX_SIZE) + 1,
  localparam int NB_TOTAL = NUM_SLOTS * NUM_BARS
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [SLOT_IW-1:0] allocSlot,
  input  logic [BAR_IW-1:0]  allocBar,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [SIZE_W-1:0]  loadSize,
  input  logic [SLOT_IW-1:0] barWrSlot,
  input  logic [BAR_IW-1:0]  barWrBar,
  input  logic [ADDR_W-1:0]  barWrData,
  input  logic [SLOT_IW-1:0] cmdWrSlot,
  input  logic               cmdWrIo,
  input  logic               cmdWrMem,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               accIsMem,
  output logic               hit,
  output logic [SLOT_IW-1:0] hitSlot,
  output logic [BAR_IW-1:0]  hitBar,
  output logic [ADDR_W-1:0]  hitOffset
);

  logic [ADDR_W-1:0] barAddr [NB_TOTAL];
  logic [SIZE_W-1:0] barSize [NB_TOTAL];
  logic [NB_TOTAL-1:0] barMem;
  logic [NUM_SLOTS-1:0] ioEn;
  logic [NUM_SLOTS-1:0] memEn;

  logic [NB_TOTAL-1:0] match;
  logic [ADDR_W-1:0]   offs [NB_TOTAL];

  int  allocIdx;
  int  wrIdx;
  logic wrOk;

  always_comb begin
    allocIdx = int'(allocSlot) * NUM_BARS + int'(allocBar);
    wrIdx    = int'(barWrSlot) * NUM_BARS + int'(barWrBar);
    wrOk     = (int'(barWrSlot) < NUM_SLOTS) && (int'(barWrBar) < NUM_BARS);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ioEn[s]  <= 1'b0;
        memEn[s] <= 1'b0;
      end else if (strobe.allocLoad && int'(allocSlot) == s) begin
        ioEn[s]  <= 1'b1;
      end else if (strobe.cmdLoad && int'(cmdWrSlot) == s) begin
        ioEn[s]  <= cmdWrIo;
        memEn[s] <= cmdWrMem;
      end
    end
  end

  for (genvar e = 0; e < NB_TOTAL; e++) begin : g_bar
    localparam int SLOT_OF = e / NUM_BARS;
    logic [ADDR_W-1:0] sizeMask;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W:0]   upper;
    logic              enOk;

    assign sizeMask = ~(ADDR_W'(barSize[e]) - ADDR_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        barAddr[e] <= '0;
        barSize[e] <= '0;
        barMem[e]  <= 1'b0;
      end else if (strobe.allocLoad && allocIdx == e) begin
        barAddr[e] <= loadAddr;
        barSize[e] <= loadSize;
        barMem[e]  <= 1'b0;
      end else if (strobe.wrLoad && wrOk && wrIdx == e && barSize[e] != '0) begin
        barAddr[e] <= barWrData & sizeMask;
        barMem[e]  <= ~barWrData[0];
      end
    end

    always_comb begin
      base = barMem[e] ? (barAddr[e] & ({ADDR_W{1'b1}} << MEM_LOW))
                       : (barAddr[e] & ({ADDR_W{1'b1}} << IO_LOW));
      upper = {1'b0, base} + (ADDR_W+1)'(barSize[e]);
      enOk  = barMem[e] ? memEn[SLOT_OF] : ioEn[SLOT_OF];
      match[e] = (barSize[e] != '0) && (barMem[e] == accIsMem) && enOk &&
                 (accAddr >= base) && ({1'b0, accAddr} < upper);
      offs[e] = accAddr - base;
    end
  end

  logic found;
  int   pick;

  always_comb begin
    found = 1'b0;
    pick  = 0;
    for (int e = NB_TOTAL - 1; e >= 0; e--) begin
      if (match[e]) begin
        found = 1'b1;
        pick  = e;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit       <= 1'b0;
      hitSlot   <= '0;
      hitBar    <= '0;
      hitOffset <= '0;
    end else begin
      hit       <= found;
      hitSlot   <= found ? SLOT_IW'(pick / NUM_BARS) : '0;
      hitBar    <= found ? BAR_IW'(pick % NUM_BARS) : '0;
      hitOffset <= found ? offs[pick] : '0;
    end
  end

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitSlot == '0 && hitBar == '0 && hitOffset == '0));

  // R8
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && $past(accIsMem)) |-> |($past(memEn) & (NUM_SLOTS'(1) << hitSlot)));

  // R8
  io_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !$past(accIsMem)) |-> |($past(ioEn) & (NUM_SLOTS'(1) << hitSlot)));

  // R6
  index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (int'(hitSlot) < NUM_SLOTS && int'(hitBar) < NUM_BARS && int'(hitOffset) < MAX_SIZE));

endmodule

// File: rtl/bar_claim_dec.sv
module bar_claim_dec
  import bar_claim_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int NUM_BARS  = 6,
  parameter int ADDR_W    = 16,
  parameter int REQ_W     = 16,
  parameter int MAX_SIZE  = 256,
  parameter int STRIDE    = 256,
  parameter int IO_LOW    = 2,
  parameter int MEM_LOW   = 4,
  parameter logic [ADDR_W-1:0] PORT_BASE = 16'h8000,
  localparam int SLOT_IW  = $clog2(NUM_SLOTS),
  localparam int BAR_IW   = $clog2(NUM_BARS),
  localparam int SIZE_W   = $clog2(MAX_SIZE) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [SLOT_IW-1:0] allocSlot,
  input  logic [BAR_IW-1:0]  allocBar,
  input  logic [REQ_W-1:0]   allocSize,
  output logic               allocAck,
  output logic               allocRefused,
  output logic [ADDR_W-1:0]  allocAddr,
  input  logic               barWrValid,
  input  logic [SLOT_IW-1:0] barWrSlot,
  input  logic [BAR_IW-1:0]  barWrBar,
  input  logic [ADDR_W-1:0]  barWrData,
  input  logic               cmdWrValid,
  input  logic [SLOT_IW-1:0] cmdWrSlot,
  input  logic               cmdWrIo,
  input  logic               cmdWrMem,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               accIsMem,
  output logic               hit,
  output logic [SLOT_IW-1:0] hitSlot,
  output logic [BAR_IW-1:0]  hitBar,
  output logic [ADDR_W-1:0]  hitOffset
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] loadAddr;
  logic [SIZE_W-1:0] loadSize;

  bar_claim_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_BARS(NUM_BARS), .ADDR_W(ADDR_W), .REQ_W(REQ_W),
    .MAX_SIZE(MAX_SIZE), .STRIDE(STRIDE), .PORT_BASE(PORT_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocSlot(allocSlot),
    .allocBar(allocBar), .allocSize(allocSize), .barWrValid(barWrValid),
    .cmdWrValid(cmdWrValid), .strobe(strobe), .loadAddr(loadAddr),
    .loadSize(loadSize), .allocAck(allocAck), .allocRefused(allocRefused),
    .allocAddr(allocAddr)
  );

  bar_claim_dp #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_BARS(NUM_BARS), .ADDR_W(ADDR_W),
    .MAX_SIZE(MAX_SIZE), .IO_LOW(IO_LOW), .MEM_LOW(MEM_LOW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocSlot(allocSlot),
    .allocBar(allocBar), .loadAddr(loadAddr), .loadSize(loadSize),
    .barWrSlot(barWrSlot), .barWrBar(barWrBar), .barWrData(barWrData),
    .cmdWrSlot(cmdWrSlot), .cmdWrIo(cmdWrIo), .cmdWrMem(cmdWrMem),
    .accAddr(accAddr), .accIsMem(accIsMem), .hit(hit), .hitSlot(hitSlot),
    .hitBar(hitBar), .hitOffset(hitOffset)
  );

endmodule

// File: tb/bar_claim_dec_tb.sv
module bar_claim_dec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 1'b0;
  logic [1:0]  allocSlot = '0;
  logic [2:0]  allocBar = '0;
  logic [15:0] allocSize = '0;
  logic        allocAck, allocRefused;
  logic [15:0] allocAddr;
  logic        barWrValid = 1'b0;
  logic [1:0]  barWrSlot = '0;
  logic [2:0]  barWrBar = '0;
  logic [15:0] barWrData = '0;
  logic        cmdWrValid = 1'b0;
  logic [1:0]  cmdWrSlot = '0;
  logic        cmdWrIo = 1'b0, cmdWrMem = 1'b0;
  logic [15:0] accAddr = '0;
  logic        accIsMem = 1'b0;
  logic        hit;
  logic [1:0]  hitSlot;
  logic [2:0]  hitBar;
  logic [15:0] hitOffset;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bar_claim_dec dut_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocSlot(allocSlot),
    .allocBar(allocBar), .allocSize(allocSize), .allocAck(allocAck),
    .allocRefused(allocRefused), .allocAddr(allocAddr), .barWrValid(barWrValid),
    .barWrSlot(barWrSlot), .barWrBar(barWrBar), .barWrData(barWrData),
    .cmdWrValid(cmdWrValid), .cmdWrSlot(cmdWrSlot), .cmdWrIo(cmdWrIo),
    .cmdWrMem(cmdWrMem), .accAddr(accAddr), .accIsMem(accIsMem), .hit(hit),
    .hitSlot(hitSlot), .hitBar(hitBar), .hitOffset(hitOffset)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        isMem;
    logic        expHit;
    logic [1:0]  slot;
    logic [2:0]  bar;
    logic [15:0] off;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{16'h8000, 1'b0, 1'b1, 2'd0, 3'd0, 16'd0},
    '{16'h800F, 1'b0, 1'b1, 2'd0, 3'd0, 16'd15},
    '{16'h8010, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0},
    '{16'h8100, 1'b0, 1'b1, 2'd0, 3'd2, 16'd0},
    '{16'h8107, 1'b0, 1'b1, 2'd0, 3'd2, 16'd7},
    '{16'h8108, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0},
    '{16'h8200, 1'b0, 1'b1, 2'd1, 3'd1, 16'd0},
    '{16'h82FF, 1'b0, 1'b1, 2'd1, 3'd1, 16'd255},
    '{16'h8300, 1'b0, 1'b1, 2'd2, 3'd3, 16'd0},
    '{16'h8301, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0},
    '{16'h7FFF, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0},
    '{16'h8000, 1'b1, 1'b0, 2'd0, 3'd0, 16'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic doAlloc(input logic [1:0] s, input logic [2:0] b, input logic [15:0] sz,
                         input logic expRef, input logic [15:0] expAddr, input string tag);
    @(negedge clk);
    allocValid = 1'b1; allocSlot = s; allocBar = b; allocSize = sz;
    @(negedge clk);
    allocValid = 1'b0;
    check({tag, " ack"}, 32'(allocAck), 32'd1);
    check({tag, " refused"}, 32'(allocRefused), 32'(expRef));
    check({tag, " addr"}, 32'(allocAddr), 32'(expAddr));
  endtask

  task automatic barWrite(input logic [1:0] s, input logic [2:0] b, input logic [15:0] d);
    @(negedge clk);
    barWrValid = 1'b1; barWrSlot = s; barWrBar = b; barWrData = d;
    @(negedge clk);
    barWrValid = 1'b0;
  endtask

  task automatic cmdWrite(input logic [1:0] s, input logic io, input logic mem);
    @(negedge clk);
    cmdWrValid = 1'b1; cmdWrSlot = s; cmdWrIo = io; cmdWrMem = mem;
    @(negedge clk);
    cmdWrValid = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic m, input logic eh, input logic [1:0] s,
                       input logic [2:0] b, input logic [15:0] o, input string tag);
    @(negedge clk);
    accAddr = a; accIsMem = m;
    @(negedge clk);
    check({tag, " hit"}, 32'(hit), 32'(eh));
    check({tag, " slot"}, 32'(hitSlot), 32'(s));
    check({tag, " bar"}, 32'(hitBar), 32'(b));
    check({tag, " offset"}, 32'(hitOffset), 32'(o));
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finishRun();
  end

  initial begin
    accAddr = 16'h8000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state of the decode outputs
    check("R1 hit", 32'(hit), 32'd0);
    check("R1 offset", 32'(hitOffset), 32'd0);
    check("R1 alloc ack", 32'(allocAck), 32'd0);

    // R1 R2: first allocation takes 0x8000
    doAlloc(2'd0, 3'd0, 16'd16, 1'b0, 16'h8000, "R1 R2 first");
    doAlloc(2'd0, 3'd2, 16'd5, 1'b0, 16'h8100, "R2 round5");
    doAlloc(2'd1, 3'd0, 16'd300, 1'b1, 16'h0000, "R3 oversize");
    doAlloc(2'd3, 3'd0, 16'd4, 1'b1, 16'h0000, "R3 badslot");
    doAlloc(2'd1, 3'd1, 16'd256, 1'b0, 16'h8200, "R2 R3 max");
    doAlloc(2'd2, 3'd0, 16'd0, 1'b0, 16'h0000, "R4 zero");
    doAlloc(2'd2, 3'd3, 16'd1, 1'b0, 16'h8300, "R2 R4 after zero");

    // R5 R6 R9 R10: table walk, I/O enabled only by allocation
    for (int i = 0; i < NVEC; i++) begin
      probe(VECS[i].addr, VECS[i].isMem, VECS[i].expHit, VECS[i].slot, VECS[i].bar,
            VECS[i].off, $sformatf("R5 R6 R10 vec%0d", i));
    end

    // R13: result registered once
    probe(16'h8004, 1'b0, 1'b1, 2'd0, 3'd0, 16'd4, "R13 before");
    @(negedge clk);
    accAddr = 16'h7000;
    #1;
    check("R13 held", 32'(hit), 32'd1);
    @(negedge clk);
    check("R13 updated", 32'(hit), 32'd0);

    // R11: write to unimplemented window ignored
    barWrite(2'd2, 3'd5, 16'h7001);
    probe(16'h7000, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, "R11 unimpl");

    // R9: overlap across slots, lower slot wins
    barWrite(2'd2, 3'd3, 16'h8201);
    probe(16'h8200, 1'b0, 1'b1, 2'd1, 3'd1, 16'd0, "R9 slots");
    // R9 R11: overlap within slot; moved window leaves old place
    barWrite(2'd0, 3'd2, 16'h8001);
    probe(16'h8004, 1'b0, 1'b1, 2'd0, 3'd0, 16'd4, "R9 bars");
    probe(16'h8100, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, "R11 moved");

    // R7: I/O base clears two low bits
    barWrite(2'd2, 3'd3, 16'h8403);
    probe(16'h8400, 1'b0, 1'b1, 2'd2, 3'd3, 16'd0, "R7 io base");
    probe(16'h8403, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, "R7 io end");

    // R8 R7: memory window gated then enabled, four low bits cleared
    barWrite(2'd2, 3'd3, 16'h850E);
    probe(16'h8500, 1'b1, 1'b0, 2'd0, 3'd0, 16'd0, "R8 mem off");
    cmdWrite(2'd2, 1'b1, 1'b1);
    probe(16'h8500, 1'b1, 1'b1, 2'd2, 3'd3, 16'd0, "R7 R12 mem base");
    probe(16'h8501, 1'b1, 1'b0, 2'd0, 3'd0, 16'd0, "R7 mem end");

    // R8 R12: slot1 window turned memory
    barWrite(2'd1, 3'd1, 16'h9000);
    probe(16'h9010, 1'b1, 1'b0, 2'd0, 3'd0, 16'd0, "R8 slot1 mem off");
    probe(16'h9010, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, "R11 type now mem");
    cmdWrite(2'd1, 1'b1, 1'b1);
    probe(16'h9010, 1'b1, 1'b1, 2'd1, 3'd1, 16'h0010, "R12 slot1 mem on");

    // R8 R12: I/O disable on slot0
    cmdWrite(2'd0, 1'b0, 1'b0);
    probe(16'h8000, 1'b0, 1'b0, 2'd0, 3'd0, 16'd0, "R8 io off");

    finishRun();
  end

endmodule